// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block is the control state machine that takes a serial link from power-on to the point where equalizer training may start. It issues single-cycle start pulses to the clock synthesizer lock loop, the termination calibration, the transmitter swing setup and the equalizer preset loader. It waits for each one to report completion, and only then raises a training enable. Clock lock and termination calibration are launched together and may finish in either order. Swing setup and preset loading follow one after the other, and both need the clock and the termination to be ready first.

Each waiting step has its own timeout limit, taken from a packed input vector. When a step stalls past its limit, the machine parks in a fault phase with a code naming that step. A whole-sequence budget counter, sized by default to 1 ms at 125 MHz, catches a bring-up that is too slow even though no single step has timed out. If clock lock drops after the first wait phase, the machine falls back to wait for the clock again. A restart input returns it to idle from any phase.

Top module: `lnk_bringup_seq`

## Requirements
- R1: While reset is held, phase_o is 0 (idle), err_code_o is 0 and all start outputs and train_en_o are low. In the first cycle after the first clock edge out of reset, phase_o is 1 (clock/termination wait), and pll_start_o and term_start_o are both high.
- R2: swing_start_o rises and phase_o becomes 2 only after pll_locked_i is high and term_done_i has been seen during phase 1. The two conditions may arrive in either order, and the termination result is latched.
- R3: A swing_done_i seen in phase 2 moves the machine to phase 3 with a preset_start_o pulse. A preset_done_i seen in phase 3 moves it to phase 4, where train_en_o is high.
- R4: Every start output is high for exactly one cycle per launch.
- R5: A done input that arrives outside the phase waiting for it has no effect. In particular, a preset_done_i pulse during phase 2 does not complete phase 3.
- R6: The limit field for step k sits at bits [k*TMO_W +: TMO_W] of tmo_limit_i (k = 0 clock, 1 termination, 2 swing, 3 preset). A step still incomplete after limit+1 cycles in its phase sends the machine to phase 7 with err_code_o equal to 1, 2, 3 or 4 respectively. A clock stall takes precedence over a termination stall.
- R7: A step that completes in the same cycle as its timeout advances normally and does not fault.
- R8: If phases 1 to 3 together last BUDGET_CYC cycles without reaching phase 4, the machine enters phase 7 with err_code_o = 5. The budget restarts on entry to phase 4 and in idle.
- R9: Loss of pll_locked_i in phase 2, 3 or 4 returns the machine to phase 1 on the next edge, drops train_en_o and pulses pll_start_o again, but not term_start_o. This wins over a done input in the same cycle, and termination is not redone.
- R10: restart_i returns the machine to phase 0 with err_code_o cleared on the next edge from any phase. This includes the cycle in which a timeout would fire.
- R11: Phase 7 and its code hold until restart_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Return to idle from any phase |
| pll_locked_i | input | 1 | Clock lock level |
| term_done_i | input | 1 | Termination calibration finished |
| swing_done_i | input | 1 | Transmitter swing configured |
| preset_done_i | input | 1 | Equalizer preset loaded |
| tmo_limit_i | input | 4*TMO_W | Per-step timeout limits, field k for step k |
| pll_start_o | output | 1 | Start pulse to the clock lock loop |
| term_start_o | output | 1 | Start pulse to termination calibration |
| swing_start_o | output | 1 | Start pulse to swing setup |
| preset_start_o | output | 1 | Start pulse to preset loading |
| train_en_o | output | 1 | Link training may run |
| phase_o | output | 3 | Current phase: 0 idle, 1 clock/termination wait, 2 swing, 3 preset, 4 training, 7 fault |
| err_code_o | output | 3 | Stalled step: 0 none, 1 clock, 2 termination, 3 swing, 4 preset, 5 budget |

## Verification
Three pairs of events can land on the same clock edge: a step completing against its own timeout, a lost clock lock against a done input, and a restart against an expiring timer. The bench provokes each pair by counting edges from phase entry and driving both inputs so that they are sampled at the same edge. For the first pair it holds the completion back to exactly the expiry cycle and expects the machine to advance. For the second it expects phase 1 with a fresh clock start pulse. For the third it expects idle with a cleared code. The timeout boundaries themselves are judged one cycle before and at the expiry edge.

// File: rtl/lnk_bringup_pkg.sv
package lnk_bringup_pkg;
   localparam int unsigned NSTEP       = 4;
   localparam int unsigned STEP_PLL    = 0;
   localparam int unsigned STEP_TERM   = 1;
   localparam int unsigned STEP_SWING  = 2;
   localparam int unsigned STEP_PRESET = 3;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_BASE   = 3'd1,
      PH_SWING  = 3'd2,
      PH_PRESET = 3'd3,
      PH_TRAIN  = 3'd4,
      PH_FAULT  = 3'd7
   } phase_e;

   typedef enum logic [2:0] {
      EC_NONE   = 3'd0,
      EC_PLL    = 3'd1,
      EC_TERM   = 3'd2,
      EC_SWING  = 3'd3,
      EC_PRESET = 3'd4,
      EC_BUDGET = 3'd5
   } err_e;
endpackage

// File: rtl/lnk_step_timer.sv
module lnk_step_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clear_i,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);
   logic [W-1:0] cnt_q;
   logic         at_lim;

   assign at_lim = (cnt_q >= limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (clear_i)           cnt_q <= '0;
      else if (run_i && !at_lim)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && at_lim;

   // R6: an expiry can only be reported while the step is being timed
   p_expire_needs_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expired_o |-> !clear_i);
endmodule

// File: rtl/lnk_seq_core.sv
module lnk_seq_core
   import lnk_bringup_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic             pll_locked_i,
   input  logic             term_done_i,
   input  logic             swing_done_i,
   input  logic             preset_done_i,
   input  logic [NSTEP-1:0] step_exp_i,
   input  logic             budget_exp_i,
   output logic [NSTEP-1:0] step_run_o,
   output logic [NSTEP-1:0] step_clr_o,
   output logic             budget_run_o,
   output logic             budget_clr_o,
   output logic             pll_start_o,
   output logic             term_start_o,
   output logic             swing_start_o,
   output logic             preset_start_o,
   output logic             train_en_o,
   output logic [2:0]       phase_o,
   output logic [2:0]       err_code_o
);
   phase_e state_q, nxt;
   err_e   code_q, code_nxt;
   logic   term_seen_q, term_ok;

   assign term_ok = term_seen_q || term_done_i;

   always_comb begin
      nxt      = state_q;
      code_nxt = code_q;
      unique case (state_q)
         PH_IDLE: nxt = PH_BASE;
         PH_BASE: begin
            if (pll_locked_i && term_ok)     nxt = PH_SWING;
            else if (step_exp_i[STEP_PLL])  begin nxt = PH_FAULT; code_nxt = EC_PLL;    end
            else if (step_exp_i[STEP_TERM]) begin nxt = PH_FAULT; code_nxt = EC_TERM;   end
            else if (budget_exp_i)          begin nxt = PH_FAULT; code_nxt = EC_BUDGET; end
         end
         PH_SWING: begin
            if (!pll_locked_i)               nxt = PH_BASE;
            else if (swing_done_i)           nxt = PH_PRESET;
            else if (step_exp_i[STEP_SWING]) begin nxt = PH_FAULT; code_nxt = EC_SWING;  end
            else if (budget_exp_i)           begin nxt = PH_FAULT; code_nxt = EC_BUDGET; end
         end
         PH_PRESET: begin
            if (!pll_locked_i)                nxt = PH_BASE;
            else if (preset_done_i)           nxt = PH_TRAIN;
            else if (step_exp_i[STEP_PRESET]) begin nxt = PH_FAULT; code_nxt = EC_PRESET; end
            else if (budget_exp_i)            begin nxt = PH_FAULT; code_nxt = EC_BUDGET; end
         end
         PH_TRAIN: if (!pll_locked_i) nxt = PH_BASE;
         PH_FAULT: nxt = PH_FAULT;
         default:  nxt = PH_IDLE;
      endcase
      if (restart_i)        nxt      = PH_IDLE;
      if (nxt == PH_IDLE)   code_nxt = EC_NONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q        <= PH_IDLE;
         code_q         <= EC_NONE;
         term_seen_q    <= 1'b0;
         pll_start_o    <= 1'b0;
         term_start_o   <= 1'b0;
         swing_start_o  <= 1'b0;
         preset_start_o <= 1'b0;
      end else begin
         state_q        <= nxt;
         code_q         <= code_nxt;
         if (state_q == PH_IDLE)                    term_seen_q <= 1'b0;
         else if (state_q == PH_BASE && term_done_i) term_seen_q <= 1'b1;
         pll_start_o    <= (nxt == PH_BASE)   && (state_q != PH_BASE);
         term_start_o   <= (nxt == PH_BASE)   && (state_q == PH_IDLE);
         swing_start_o  <= (nxt == PH_SWING)  && (state_q != PH_SWING);
         preset_start_o <= (nxt == PH_PRESET) && (state_q != PH_PRESET);
      end
   end

   assign step_run_o[STEP_PLL]    = (state_q == PH_BASE)   && !pll_locked_i;
   assign step_run_o[STEP_TERM]   = (state_q == PH_BASE)   && !term_ok;
   assign step_run_o[STEP_SWING]  = (state_q == PH_SWING)  && !swing_done_i;
   assign step_run_o[STEP_PRESET] = (state_q == PH_PRESET) && !preset_done_i;
   assign step_clr_o[STEP_PLL]    = (state_q != PH_BASE);
   assign step_clr_o[STEP_TERM]   = (state_q != PH_BASE);
   assign step_clr_o[STEP_SWING]  = (state_q != PH_SWING);
   assign step_clr_o[STEP_PRESET] = (state_q != PH_PRESET);
   assign budget_run_o = (state_q == PH_BASE) || (state_q == PH_SWING) || (state_q == PH_PRESET);
   assign budget_clr_o = (state_q == PH_IDLE) || (state_q == PH_TRAIN);

   assign train_en_o = (state_q == PH_TRAIN);
   assign phase_o    = state_q;
   assign err_code_o = code_q;

   // R1: termination is only ever launched together with the clock
   p_term_with_pll_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_start_o |-> pll_start_o);
   // R2: swing setup is launched only after a cycle with lock present
   p_swing_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swing_start_o |-> $past(pll_locked_i));
   // R4: start outputs are single-cycle
   p_swing_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swing_start_o |=> !swing_start_o);
   p_preset_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      preset_start_o |=> !preset_start_o);
   p_pll_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pll_start_o |=> !pll_start_o);
   // R9: training is never enabled across a cycle without lock
   p_train_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      train_en_o |-> $past(pll_locked_i));
   // R10: restart always lands in idle
   p_restart_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (phase_o == PH_IDLE) && (err_code_o == EC_NONE));
   // R11: fault is sticky without restart
   p_fault_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == PH_FAULT) && !restart_i |=> (phase_o == PH_FAULT) && $stable(err_code_o));
   // R6: a code is only shown in the fault phase
   p_code_in_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_code_o != EC_NONE) |-> (phase_o == PH_FAULT));
endmodule

// File: rtl/lnk_bringup_seq.sv
module lnk_bringup_seq
   import lnk_bringup_pkg::*;
#(
   parameter int unsigned TMO_W      = 16,
   parameter int unsigned BUDGET_CYC = 125000
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   restart_i,
   input  logic                   pll_locked_i,
   input  logic                   term_done_i,
   input  logic                   swing_done_i,
   input  logic                   preset_done_i,
   input  logic [NSTEP*TMO_W-1:0] tmo_limit_i,
   output logic                   pll_start_o,
   output logic                   term_start_o,
   output logic                   swing_start_o,
   output logic                   preset_start_o,
   output logic                   train_en_o,
   output logic [2:0]             phase_o,
   output logic [2:0]             err_code_o
);
   localparam int unsigned BUD_W = $clog2(BUDGET_CYC + 1);
   localparam logic [BUD_W-1:0] BUD_LIM = BUD_W'(BUDGET_CYC - 1);

   if (TMO_W < 2 || TMO_W > 24) begin : g_bad_tmo_w
      $error("TMO_W must lie between 2 and 24");
   end
   if (BUDGET_CYC < 4) begin : g_bad_budget
      $error("BUDGET_CYC must be at least 4");
   end

   logic [NSTEP-1:0] step_run, step_clr, step_exp;
   logic             bud_run, bud_clr, bud_exp;

   for (genvar k = 0; k < NSTEP; k++) begin : g_step
      lnk_step_timer #(.W(TMO_W)) u_tmr (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .clear_i   (step_clr[k]),
         .run_i     (step_run[k]),
         .limit_i   (tmo_limit_i[k*TMO_W +: TMO_W]),
         .expired_o (step_exp[k])
      );
   end

   lnk_step_timer #(.W(BUD_W)) u_budget (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (bud_clr),
      .run_i     (bud_run),
      .limit_i   (BUD_LIM),
      .expired_o (bud_exp)
   );

   lnk_seq_core u_core (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .restart_i      (restart_i),
      .pll_locked_i   (pll_locked_i),
      .term_done_i    (term_done_i),
      .swing_done_i   (swing_done_i),
      .preset_done_i  (preset_done_i),
      .step_exp_i     (step_exp),
      .budget_exp_i   (bud_exp),
      .step_run_o     (step_run),
      .step_clr_o     (step_clr),
      .budget_run_o   (bud_run),
      .budget_clr_o   (bud_clr),
      .pll_start_o    (pll_start_o),
      .term_start_o   (term_start_o),
      .swing_start_o  (swing_start_o),
      .preset_start_o (preset_start_o),
      .train_en_o     (train_en_o),
      .phase_o        (phase_o),
      .err_code_o     (err_code_o)
   );

   // R8: a budget expiry while waiting always ends in fault or progress
   p_budget_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bud_exp && !restart_i && !step_exp[STEP_PLL] && !step_exp[STEP_TERM]
         && (phase_o == 3'd1) && !pll_locked_i
      |=> (phase_o == 3'd7) && (err_code_o == 3'd5));
endmodule

// File: tb/lnk_bringup_seq_tb.sv
module lnk_bringup_seq_tb_top;
   localparam int TW = 8;
   localparam int BUD = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0, locked = 1'b0, tdone = 1'b0, sdone = 1'b0, pdone = 1'b0;
   logic [TW-1:0] lim_pll = '0, lim_term = '0, lim_swing = '0, lim_pre = '0;
   logic pll_st, term_st, swing_st, pre_st, train;
   logic [2:0] phase, code;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   lnk_bringup_seq #(.TMO_W(TW), .BUDGET_CYC(BUD)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .pll_locked_i(locked),
      .term_done_i(tdone), .swing_done_i(sdone), .preset_done_i(pdone),
      .tmo_limit_i({lim_pre, lim_swing, lim_term, lim_pll}),
      .pll_start_o(pll_st), .term_start_o(term_st), .swing_start_o(swing_st),
      .preset_start_o(pre_st), .train_en_o(train), .phase_o(phase), .err_code_o(code));

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ends one cycle after reset release: phase 1, index 0 of the wait
   task automatic do_reset(input int lp, input int lt, input int ls, input int lr);
      rst_n = 1'b0; restart = 0; locked = 0; tdone = 0; sdone = 0; pdone = 0;
      lim_pll = TW'(lp); lim_term = TW'(lt); lim_swing = TW'(ls); lim_pre = TW'(lr);
      tick(3);
      chk("R1", "phase in reset", phase, 0);
      chk("R1", "code in reset", code, 0);
      chk("R1", "starts in reset", {pll_st, term_st, swing_st, pre_st, train}, 0);
      rst_n = 1'b1;
      tick();
      chk("R1", "phase after launch", phase, 1);
      chk("R1", "pll and term start", {pll_st, term_st}, 3);
   endtask

   task automatic t_normal_flow();
      do_reset(200, 200, 200, 200);
      tdone = 1; tick(); tdone = 0;
      chk("R4", "launch pulses drop", {pll_st, term_st}, 0);
      chk("R2", "no swing without lock", phase, 1);
      tick(3);
      chk("R2", "still waiting for lock", phase, 1);
      locked = 1; tick();
      chk("R2", "phase swing", phase, 2);
      chk("R2", "swing start", swing_st, 1);
      pdone = 1; tick(); pdone = 0;
      chk("R4", "swing start single", swing_st, 0);
      chk("R5", "early preset done ignored", phase, 2);
      sdone = 1; tick(); sdone = 0;
      chk("R3", "phase preset", phase, 3);
      chk("R3", "preset start", pre_st, 1);
      tick(2);
      chk("R5", "preset still waiting", phase, 3);
      chk("R4", "preset start single", pre_st, 0);
      pdone = 1; tick(); pdone = 0;
      chk("R3", "phase train", phase, 4);
      chk("R3", "train enable", train, 1);
      // lock loss in training
      locked = 0; tick();
      chk("R9", "back to wait", phase, 1);
      chk("R9", "train dropped", train, 0);
      chk("R9", "pll relaunch / no term", {pll_st, term_st}, 2);
      locked = 1; tick();
      chk("R9", "term result retained", phase, 2);
      // lock loss together with swing done
      sdone = 1; locked = 0; tick(); sdone = 0;
      chk("R9", "lock loss beats done", phase, 1);
      chk("R9", "pll relaunch", pll_st, 1);
   endtask

   task automatic t_pll_timeout();
      do_reset(5, 100, 100, 100);
      tick(5);
      chk("R6", "one before pll expiry", phase, 1);
      tick();
      chk("R6", "pll expiry phase", phase, 7);
      chk("R6", "pll code", code, 1);
      locked = 1; tdone = 1; tick(3); tdone = 0;
      chk("R11", "fault holds", phase, 7);
      chk("R11", "code holds", code, 1);
      restart = 1; tick(); restart = 0;
      chk("R10", "restart to idle", phase, 0);
      chk("R10", "code cleared", code, 0);
      tick();
      chk("R10", "relaunch after restart", {phase, pll_st, term_st}, {3'd1, 2'b11});
   endtask

   task automatic t_both_timeout();
      do_reset(4, 4, 100, 100);
      tick(5);
      chk("R6", "clock wins over term", code, 1);
   endtask

   task automatic t_term_timeout();
      do_reset(100, 3, 100, 100);
      locked = 1;
      tick(3);
      chk("R6", "one before term expiry", phase, 1);
      tick();
      chk("R6", "term code", code, 2);
   endtask

   task automatic t_done_at_expiry();
      do_reset(3, 100, 100, 100);
      tdone = 1; tick(); tdone = 0;
      tick(2);
      locked = 1; tick();
      chk("R7", "lock at expiry cycle advances", phase, 2);
      chk("R7", "no code", code, 0);
   endtask

   task automatic t_swing_timeout();
      do_reset(100, 100, 2, 100);
      locked = 1; tdone = 1; tick(); tdone = 0;
      chk("R2", "lock then term same cycle", phase, 2);
      tick(2);
      chk("R6", "one before swing expiry", phase, 2);
      tick();
      chk("R6", "swing code", {phase, code}, {3'd7, 3'd3});
   endtask

   task automatic t_preset_timeout();
      do_reset(100, 100, 100, 2);
      locked = 1; tdone = 1; tick(); tdone = 0;
      sdone = 1; tick(); sdone = 0;
      tick(2);
      chk("R6", "one before preset expiry", phase, 3);
      tick();
      chk("R6", "preset code", {phase, code}, {3'd7, 3'd4});
   endtask

   task automatic t_budget();
      do_reset(200, 200, 200, 200);
      tdone = 1; tick(); tdone = 0;
      tick(BUD - 2);
      chk("R8", "one before budget", phase, 1);
      tick();
      chk("R8", "budget fault", phase, 7);
      chk("R8", "budget code", code, 5);
   endtask

   task automatic t_restart_vs_expiry();
      do_reset(2, 100, 100, 100);
      tick(2);
      restart = 1; tick(); restart = 0;
      chk("R10", "restart beats expiry", {phase, code}, 0);
   endtask

   initial begin
      t_normal_flow();
      t_pll_timeout();
      t_both_timeout();
      t_term_timeout();
      t_done_at_expiry();
      t_swing_timeout();
      t_preset_timeout();
      t_budget();
      t_restart_vs_expiry();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule